// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader with Chained Hand-off

This block runs once after reset and fills one device's configuration register file from an external serial EEPROM. Several devices share that EEPROM. Each loader waits until its active-low start input goes low. It then reads the common header at the bottom of the EEPROM and locates its own 37-byte record. It checks the record against a trailing check byte, stores the record in its register file, and finally pulls its active-low done output low. That done output drives the start input of the next device in the chain. As a result, only one loader drives the shared bus at any time.

The bus-level transfer is abstracted into a byte read port. The loader holds a request together with the device address byte, a word address and an address-width flag. It holds these until the port returns either one acknowledge cycle carrying the data byte or one not-acknowledge cycle. The header flags choose three things: whether a CRC protects the record, whether the record start comes from a pointer table, and whether word addresses are one byte or two. Any failed read or check leaves the register file at its defaults and sets an error flag. The token is still passed on, so the chain does not stall.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: In reset and afterwards until loading begins: `done_no` is 1, `err_o` is 0, `rd_req_o` is 0 and every byte of `cfg_o` is 0x00.
- R2: No read is requested while `rd_en_ni` is high. The first request appears in the cycle after the first clock edge that samples `rd_en_ni` low. While loading is in progress, `rd_req_o` stays high until the last read completes.
- R3: Every request carries device address byte 0xA0. A request keeps its address until an acknowledge or a not-acknowledge arrives. The next address appears in the cycle after the acknowledge.
- R4: `own_addr_o` equals 0xB0 OR (`strap_i` shifted left by one), so strap 0 gives 0xB0 and strap 3 gives 0xB6.
- R5: Header bytes are read from addresses 0, 1 and 2, in that order. Header byte 0 holds the flags: bit 0 enables the CRC, bit 1 selects pointer lookup, and bit 2 selects two-byte word addresses. Header byte 0 is always read with `rd_wide_o`=0. Every later read uses `rd_wide_o` equal to flag bit 2.
- R6: With bit 1 clear, the record is read at addresses S..S+36 in ascending order, with S = 3 + strap×37. The check byte is then read at S+37.
- R7: With bit 1 set, one pointer byte is read at address 3 + strap. The record then starts at S = that byte's value, with the same order as in R6.
- R8: With bit 0 set, the check byte must equal the CRC-8 of the 37 record bytes: polynomial 0x07, initial value 0x00, most significant bit first, no final XOR. With bit 0 clear, the check byte must equal 0xA5. Any other value is a failure.
- R9: On success, after the edge that accepts the check byte, `done_no` is 0 and `err_o` is 0. Record byte k sits at `cfg_o[8k+7:8k]`.
- R10: A not-acknowledge on any read, or a failed check, ends loading at that edge. After it, `err_o` is 1, `done_no` is 0, every `cfg_o` byte is 0x00 and no more reads are requested.
- R11: Once `done_no` is low it stays low and no further requests are issued until reset, whatever `rd_en_ni` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 4 | Device strap bits, select record and own address |
| rd_en_ni | input | 1 | Active-low start token from previous device |
| done_no | output | 1 | Active-low done token to next device |
| err_o | output | 1 | Load failed, defaults kept |
| own_addr_o | output | 8 | Device's own slave address byte |
| rd_req_o | output | 1 | Byte read request, held until answered |
| rd_dev_o | output | 8 | EEPROM device address byte |
| rd_addr_o | output | 16 | EEPROM word address |
| rd_wide_o | output | 1 | Send two-byte word address |
| rd_ack_i | input | 1 | Read completed, data valid this cycle |
| rd_nack_i | input | 1 | Read refused by the bus |
| rd_data_i | input | 8 | Read data byte |
| cfg_o | output | 296 | Configuration register file, byte k at bits 8k+7:8k |

## Verification
The assertions check the following on every cycle: a pending request holds its address until it is answered, reads start only after the token was seen low, done never returns high, the error flag implies done, and done only falls on the edge that completes a read. The bench scenarios are the only place where the content is checked: the exact address sequence under both start-address modes and both address widths, the CRC and fixed-tag acceptance rules, the register contents after success, and the return to defaults after a not-acknowledge or a bad check byte.

// File: rtl/ecl_pkg.sv
package ecl_pkg;
  typedef enum logic [2:0] {
    ST_WAIT, ST_HDR, ST_PTR, ST_REC, ST_CHK, ST_DONE
  } ecl_state_e;

  localparam int FLG_CRC  = 0;
  localparam int FLG_MAP  = 1;
  localparam int FLG_WIDE = 2;

  function automatic logic [7:0] crc8_step(logic [7:0] crc, logic [7:0] data, logic [7:0] poly);
    logic [7:0] c;
    c = crc ^ data;
    for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/ecl_crc8.sv
module ecl_crc8 import ecl_pkg::*; #(
  parameter logic [7:0] POLY = 8'h07,
  parameter logic [7:0] INIT = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  logic [7:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= INIT;
    else if (clr_i) crc_q <= INIT;
    else if (en_i)  crc_q <= crc8_step(crc_q, data_i, POLY);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/ecl_regfile.sv
module ecl_regfile #(
  parameter int         NBYTES = 37,
  parameter logic [7:0] DFLT   = 8'h00,
  localparam int        IDX_W  = $clog2(NBYTES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [7:0]            data_i,
  output logic [NBYTES*8-1:0]   flat_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               q <= DFLT;
      else if (clr_i)                            q <= DFLT;
      else if (we_i && idx_i == IDX_W'(g))       q <= data_i;
    end
    assign flat_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/ecl_addr_gen.sv
module ecl_addr_gen import ecl_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int STRAP_W   = 4,
  parameter int HDR_BYTES = 3,
  parameter int REC_BYTES = 37,
  localparam int IDX_W    = $clog2(REC_BYTES + 1)
) (
  input  ecl_state_e          state_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [STRAP_W-1:0]  strap_i,
  input  logic [ADDR_W-1:0]   base_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [ADDR_W-1:0]   auto_base_o
);
  assign auto_base_o = ADDR_W'(HDR_BYTES) + ADDR_W'(strap_i) * ADDR_W'(REC_BYTES);

  always_comb begin
    unique case (state_i)
      ST_HDR:  addr_o = ADDR_W'(idx_i);
      ST_PTR:  addr_o = ADDR_W'(HDR_BYTES) + ADDR_W'(strap_i);
      ST_REC:  addr_o = base_i + ADDR_W'(idx_i);
      ST_CHK:  addr_o = base_i + ADDR_W'(REC_BYTES);
      default: addr_o = '0;
    endcase
  end
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader import ecl_pkg::*; #(
  parameter int         ADDR_W    = 16,
  parameter int         STRAP_W   = 4,
  parameter int         HDR_BYTES = 3,
  parameter int         REC_BYTES = 37,
  parameter logic [7:0] EE_DEV    = 8'hA0,
  parameter logic [7:0] SLV_BASE  = 8'hB0,
  parameter logic [7:0] CRC_POLY  = 8'h07,
  parameter logic [7:0] CRC_INIT  = 8'h00,
  parameter logic [7:0] NOCRC_TAG = 8'hA5,
  parameter logic [7:0] DFLT_BYTE = 8'h00,
  localparam int        IDX_W     = $clog2(REC_BYTES + 1),
  localparam int        CFG_W     = REC_BYTES * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               rd_en_ni,
  output logic               done_no,
  output logic               err_o,
  output logic [7:0]         own_addr_o,
  output logic               rd_req_o,
  output logic [7:0]         rd_dev_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic               rd_wide_o,
  input  logic               rd_ack_i,
  input  logic               rd_nack_i,
  input  logic [7:0]         rd_data_i,
  output logic [CFG_W-1:0]   cfg_o
);
  ecl_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [2:0]        flg_q, flg_d;
  logic [ADDR_W-1:0] base_q, base_d, auto_base;
  logic              err_q, err_d;
  logic              rx, nack;
  logic              rf_we, rf_clr, crc_en, crc_clr;
  logic [7:0]        crc_val, chk_exp;

  assign rd_req_o   = (state_q == ST_HDR) || (state_q == ST_PTR) ||
                      (state_q == ST_REC) || (state_q == ST_CHK);
  assign rx         = rd_req_o && rd_ack_i && !rd_nack_i;
  assign nack       = rd_req_o && rd_nack_i;
  assign rd_dev_o   = EE_DEV;
  assign rd_wide_o  = flg_q[FLG_WIDE];
  assign done_no    = (state_q != ST_DONE);
  assign err_o      = err_q;
  assign own_addr_o = SLV_BASE | (8'(strap_i) << 1);
  assign chk_exp    = flg_q[FLG_CRC] ? crc_val : NOCRC_TAG;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    flg_d   = flg_q;
    base_d  = base_q;
    err_d   = err_q;
    rf_we   = 1'b0;
    rf_clr  = 1'b0;
    crc_en  = 1'b0;
    crc_clr = 1'b0;
    unique case (state_q)
      ST_WAIT: if (!rd_en_ni) begin
        state_d = ST_HDR;
        idx_d   = '0;
        crc_clr = 1'b1;
      end
      ST_HDR: if (rx) begin
        if (idx_q == '0) flg_d = rd_data_i[2:0];
        if (idx_q == IDX_W'(HDR_BYTES - 1)) begin
          idx_d = '0;
          if (flg_d[FLG_MAP]) state_d = ST_PTR;
          else begin
            base_d  = auto_base;
            state_d = ST_REC;
          end
        end else idx_d = idx_q + IDX_W'(1);
      end
      ST_PTR: if (rx) begin
        base_d  = ADDR_W'(rd_data_i);
        idx_d   = '0;
        state_d = ST_REC;
      end
      ST_REC: if (rx) begin
        rf_we  = 1'b1;
        crc_en = 1'b1;
        if (idx_q == IDX_W'(REC_BYTES - 1)) state_d = ST_CHK;
        else idx_d = idx_q + IDX_W'(1);
      end
      ST_CHK: if (rx) begin
        if (rd_data_i != chk_exp) begin
          err_d  = 1'b1;
          rf_clr = 1'b1;
        end
        state_d = ST_DONE;
      end
      default: ;
    endcase
    // a refused read aborts from any phase, token still passed
    if (nack) begin
      rf_we   = 1'b0;
      crc_en  = 1'b0;
      rf_clr  = 1'b1;
      err_d   = 1'b1;
      state_d = ST_DONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      idx_q   <= '0;
      flg_q   <= '0;
      base_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      flg_q   <= flg_d;
      base_q  <= base_d;
      err_q   <= err_d;
    end
  end

  ecl_addr_gen #(
    .ADDR_W(ADDR_W), .STRAP_W(STRAP_W), .HDR_BYTES(HDR_BYTES), .REC_BYTES(REC_BYTES)
  ) u_addr (
    .state_i(state_q), .idx_i(idx_q), .strap_i(strap_i), .base_i(base_q),
    .addr_o(rd_addr_o), .auto_base_o(auto_base)
  );

  ecl_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(crc_clr), .en_i(crc_en),
    .data_i(rd_data_i), .crc_o(crc_val)
  );

  ecl_regfile #(.NBYTES(REC_BYTES), .DFLT(DFLT_BYTE)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rf_clr), .we_i(rf_we),
    .idx_i(idx_q), .data_i(rd_data_i), .flat_o(cfg_o)
  );

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i && !rd_nack_i |=> rd_req_o && $stable(rd_addr_o));
  // R2
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_req_o) |-> $past(!rd_en_ni));
  // R11
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_no |=> !done_no && !rd_req_o);
  // R10
  err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !done_no);
  // R9
  done_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_no) |-> $past(rd_req_o && (rd_ack_i || rd_nack_i)));
endmodule

// File: tb/eeprom_cfg_loader_tb.sv
module eeprom_cfg_loader_tb;
  localparam int REC = 37;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [3:0]   strap_i;
  logic         rd_en_ni;
  logic         done_no, err_o, rd_req_o, rd_wide_o;
  logic [7:0]   own_addr_o, rd_dev_o, rd_data_i;
  logic [15:0]  rd_addr_o;
  logic         rd_ack_i, rd_nack_i;
  logic [REC*8-1:0] cfg_o;

  logic [7:0] mem [0:1023];
  int vecs = 0, bad = 0, cyc = 0;

  always #10 clk_i = ~clk_i;

  eeprom_cfg_loader u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_i), .rd_en_ni(rd_en_ni),
    .done_no(done_no), .err_o(err_o), .own_addr_o(own_addr_o),
    .rd_req_o(rd_req_o), .rd_dev_o(rd_dev_o), .rd_addr_o(rd_addr_o),
    .rd_wide_o(rd_wide_o), .rd_ack_i(rd_ack_i), .rd_nack_i(rd_nack_i),
    .rd_data_i(rd_data_i), .cfg_o(cfg_o)
  );

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      vecs++; bad++;
      $display("FAIL R11 watchdog: act=%0d cycles exp<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [REC*8-1:0] act, input logic [REC*8-1:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fb = r[7] ^ d[b];
      r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic run(input logic [3:0] strap, input logic [7:0] flags, input logic [7:0] ptr,
                     input bit corrupt, input int nack_at, input int seed);
    int qa[$];
    bit qw[$];
    int base, pos, wcnt, guard, dly;
    logic [7:0] crc, cb;
    logic [REC*8-1:0] ecfg;
    bit ok, fin, nacked, drv_ack, drv_nack;
    string atag, ftag;

    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 13 + seed * 29 + 5) & 255);
    mem[0] = flags; mem[1] = 8'd37; mem[2] = 8'h00;
    if (flags[1]) begin mem[3 + int'(strap)] = ptr; base = int'(ptr); end
    else base = 3 + int'(strap) * 37;
    crc = 8'h00;
    for (int k = 0; k < REC; k++) crc = ref_crc(crc, mem[base + k]);
    cb = flags[0] ? crc : 8'hA5;
    if (corrupt) cb = cb ^ 8'h5A;
    mem[base + REC] = cb;

    qa.push_back(0); qw.push_back(1'b0);
    qa.push_back(1); qw.push_back(flags[2]);
    qa.push_back(2); qw.push_back(flags[2]);
    if (flags[1]) begin qa.push_back(3 + int'(strap)); qw.push_back(flags[2]); end
    for (int k = 0; k <= REC; k++) begin qa.push_back(base + k); qw.push_back(flags[2]); end

    ok = (nack_at < 0) && !corrupt;
    for (int k = 0; k < REC; k++) ecfg[k*8 +: 8] = ok ? mem[base + k] : 8'h00;
    atag = flags[1] ? "R7" : "R6";
    ftag = (nack_at >= 0) ? "R10" : (corrupt ? "R8" : "R9");

    rst_ni = 1'b0; rd_en_ni = 1'b1; rd_ack_i = 1'b0; rd_nack_i = 1'b0;
    rd_data_i = 8'h00; strap_i = strap;
    repeat (2) @(negedge clk_i);
    chk("R1", "done in reset", done_no, 1);
    chk("R1", "err in reset", err_o, 0);
    chk("R1", "req in reset", rd_req_o, 0);
    chk("R1", "cfg in reset", cfg_o, 0);
    rst_ni = 1'b1;
    repeat (4) begin
      @(negedge clk_i);
      chk("R2", "req before token", rd_req_o, 0);
      chk("R2", "done before token", done_no, 1);
    end
    chk("R4", "own address", own_addr_o, 8'hB0 | {3'b000, strap, 1'b0});

    rd_en_ni = 1'b0;
    pos = 0; wcnt = 0; guard = 0;
    nacked = 0; drv_ack = 0; drv_nack = 0; fin = 0;
    while (!fin && guard < 5000) begin
      @(negedge clk_i);
      guard++;
      if (drv_nack) nacked = 1;
      else if (drv_ack) pos++;
      drv_ack = 0; drv_nack = 0; rd_ack_i = 1'b0; rd_nack_i = 1'b0;
      fin = nacked || (pos == qa.size());
      chk("R9", "done during load", done_no, fin ? 1'b0 : 1'b1);
      chk("R2", "request level", rd_req_o, fin ? 1'b0 : 1'b1);
      if (!fin) begin
        chk(atag, "read address", rd_addr_o, qa[pos]);
        chk("R5", "address width", rd_wide_o, qw[pos]);
        chk("R3", "device byte", rd_dev_o, 8'hA0);
        dly = (seed == 1) ? 0 : ((pos * seed + 1) % 3);
        if (wcnt >= dly) begin
          if (pos == nack_at) begin
            rd_nack_i = 1'b1; drv_nack = 1;
          end else begin
            rd_ack_i  = 1'b1; drv_ack = 1;
            rd_data_i = mem[qw[pos] ? (qa[pos] & 1023) : (qa[pos] & 255)];
          end
          wcnt = 0;
        end else wcnt++;
      end
    end
    chk(ftag, "error flag", err_o, ok ? 1'b0 : 1'b1);
    chk(ftag, "register file", cfg_o, ecfg);
    rd_en_ni = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      chk("R11", "req after done", rd_req_o, 0);
      chk("R11", "done held", done_no, 0);
    end
  endtask

  initial begin
    run(4'd0,  8'h01, 8'h00, 0, -1, 1);  // CRC on, computed start
    run(4'd3,  8'h00, 8'h00, 0, -1, 2);  // CRC off, fixed tag accepted
    run(4'd5,  8'h03, 8'h40, 0, -1, 3);  // pointer lookup
    run(4'd12, 8'h05, 8'h00, 0, -1, 4);  // two-byte addresses, high record
    run(4'd1,  8'h01, 8'h00, 1, -1, 5);  // CRC mismatch
    run(4'd2,  8'h00, 8'h00, 1, -1, 6);  // fixed tag wrong
    run(4'd4,  8'h01, 8'h00, 0, 1,  7);  // refused in header
    run(4'd6,  8'h07, 8'h90, 0, 10, 8);  // refused mid-record
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule